// File: doc/BRIEF.md
# MDIO Station-Management Master

This block lets a processor reach the management registers of an Ethernet PHY over the two-wire MDIO interface. Software programs the target PHY and register numbers into an address register. To write, it stores the 16-bit value in the write-data register, and that store by itself launches the frame. To read, it sets the read bit in the command register. The engine then shifts out a 64-bit clause-22 frame on MDIO, timed by an MDC clock that it divides down from the system clock.

During a read the block releases MDIO from the turnaround onward. It samples the PHY's reply on each rising MDC edge, most significant bit first. When the frame ends it moves the 16 captured bits into the read-data register. A status register reports a busy flag and a not-valid flag, and a read has finished once both are low. A management-reset bit in the configuration register holds the engine idle. A two-bit divider select sets the MDC rate, and its slowest setting (divide by 40) keeps MDC at or below 2.5 MHz from a 100 MHz system clock.

Register map (3-bit select): 0 configuration, 1 command, 2 address, 3 write data, 4 read data, 5 status. Other selects read as zero.

Top module: `mdio_master`

## Requirements
- R1: The address register (select 2) keeps the PHY number in bits 12:8 and the PHY register number in bits 4:0. All its other bits read back as zero.
- R2: When the engine is idle and not held in management reset, a write to select 3 starts a write frame. The frame is 32 ones, then 01, then opcode 01, then PHY address, register address, turnaround 1 0, and the written 16 bits MSB first. The master drives MDIO for all 64 bits. Select 3 reads back the last value written.
- R3: When the engine is idle and not held in reset, a write to select 1 with bit 0 set starts a read frame with opcode 10. MDIO output enable falls for bits 46 to 63 (turnaround and data). The command bit reads back as written until software clears it.
- R4: Status (select 5) bit 0 is busy. It is high from the first clock edge after a start, which is well inside 30 cycles, and it stays high for exactly 64 MDC periods.
- R5: Status bit 1 (not valid) rises with busy when a read starts and falls with busy at the end of the read frame. At that point select 4 holds the 16 bits sampled on MDIO at the rising MDC edges of bits 48 to 63, with the first sample as the MSB.
- R6: Configuration bit 15 is the management reset. From the edge after it is set, busy and not-valid are low, MDC is low, MDIO is released and start requests are ignored. Clearing the bit releases the engine.
- R7: Configuration bits 1:0 select the MDC divisor: 0 gives 4, 1 gives 10, 2 gives 20 and 3 gives 40. The reset value is 3. Each bit lasts one divisor of cycles, with MDC low for the first half and high for the second. The divisor is latched when a frame starts.
- R8: When idle, MDC is low and MDIO output enable is low. During a frame, MDIO out changes only at a falling MDC edge.
- R9: A start request made while busy is high, including the last cycle of a frame, launches no frame.
- R10: Selects 6 and 7 read as zero. The status register's bits above bit 1 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 3 | Register select |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Combinational readback of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable. Low means released |
| mdioIn | input | 1 | MDIO value seen at the pin |

## Verification
Two events can fall on the same edge. A frame can finish on the very edge where a new start request arrives, or a start can be requested while a management reset is in effect. The bench issues a write-data store timed to the last cycle of a frame, and read commands during a running frame and under reset. A cycle-level reference model predicts that none of these launch a frame, and it compares MDC, MDIO, output enable and the selected register on every clock, so a frame that starts when it should not shows up at once as a mismatch.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_SEL_W  = 3;
  localparam int REG_W      = 16;
  localparam int FRAME_LEN  = 64;
  localparam int BIT_W      = $clog2(FRAME_LEN);
  localparam int TA_START   = 46;
  localparam int DATA_START = 48;

  localparam logic [REG_SEL_W-1:0] SEL_CFG   = 3'd0;
  localparam logic [REG_SEL_W-1:0] SEL_CMD   = 3'd1;
  localparam logic [REG_SEL_W-1:0] SEL_ADDR  = 3'd2;
  localparam logic [REG_SEL_W-1:0] SEL_WDATA = 3'd3;
  localparam logic [REG_SEL_W-1:0] SEL_RDATA = 3'd4;
  localparam logic [REG_SEL_W-1:0] SEL_STAT  = 3'd5;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadWr;   // build a write frame
    logic loadRd;   // build a read frame
    logic shift;    // advance to the next bit at a falling MDC edge
    logic capture;  // take one reply bit at a rising MDC edge
    logic latch;    // move the captured word into read data
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV0  = 4,
  parameter int DIV1  = 10,
  parameter int DIV2  = 20,
  parameter int DIV3  = 40,
  parameter int CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mgmtRst,
  input  logic [1:0]           clkSel,
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic                 cmdBit,
  output mdioStrobe_t          strb,
  output logic                 busy,
  output logic                 notValid,
  output logic                 mdc,
  output logic                 mdioOe
);
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divLat;
  logic [CNT_W-1:0] selDiv;
  logic [CNT_W-1:0] halfDiv;
  logic [BIT_W-1:0] bitIdx;
  logic             isRead;
  logic             goWr, goRd, atRise, atEnd, lastBit;

  always_comb begin
    case (clkSel)
      2'd0:    selDiv = CNT_W'(DIV0);
      2'd1:    selDiv = CNT_W'(DIV1);
      2'd2:    selDiv = CNT_W'(DIV2);
      default: selDiv = CNT_W'(DIV3);
    endcase
  end

  assign halfDiv = divLat >> 1;
  assign goWr    = regWrEn && (regSel == SEL_WDATA) && !busy && !mgmtRst;
  assign goRd    = regWrEn && (regSel == SEL_CMD) && cmdBit && !busy && !mgmtRst;
  assign atRise  = busy && (divCnt == halfDiv - 1'b1);
  assign atEnd   = busy && (divCnt == divLat - 1'b1);
  assign lastBit = (bitIdx == BIT_W'(FRAME_LEN - 1));

  assign strb.loadWr  = goWr;
  assign strb.loadRd  = goRd;
  assign strb.shift   = atEnd && !lastBit;
  assign strb.capture = atRise && isRead && (bitIdx >= BIT_W'(DATA_START));
  assign strb.latch   = atEnd && lastBit && isRead;

  assign mdioOe = busy && (!isRead || (bitIdx < BIT_W'(TA_START)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      notValid <= 1'b0;
      isRead   <= 1'b0;
      mdc      <= 1'b0;
      divCnt   <= '0;
      bitIdx   <= '0;
      divLat   <= CNT_W'(DIV3);
    end else if (mgmtRst) begin
      busy     <= 1'b0;
      notValid <= 1'b0;
      isRead   <= 1'b0;
      mdc      <= 1'b0;
      divCnt   <= '0;
      bitIdx   <= '0;
    end else if (busy) begin
      if (atEnd) begin
        divCnt <= '0;
        mdc    <= 1'b0;
        if (lastBit) begin
          busy     <= 1'b0;
          notValid <= 1'b0;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
        if (atRise) mdc <= 1'b1;
      end
    end else if (goWr || goRd) begin
      busy     <= 1'b1;
      isRead   <= goRd;
      notValid <= goRd;
      divCnt   <= '0;
      bitIdx   <= '0;
      mdc      <= 1'b0;
      divLat   <= selDiv;
    end
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  mdioStrobe_t          strb,
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic [REG_W-1:0]     regWrData,
  input  logic                 mdioIn,
  input  logic                 busy,
  input  logic                 notValid,
  output logic [REG_W-1:0]     regRdData,
  output logic                 mdioOut,
  output logic                 mgmtRst,
  output logic [1:0]           clkSel
);
  localparam logic [33:0] PRE_START = {32'hFFFF_FFFF, 2'b01};

  logic                 cmdRd;
  logic [4:0]           phyAddr, phyReg;
  logic [REG_W-1:0]     wrWord, rdWord, rdShift;
  logic [FRAME_LEN-1:0] frame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mgmtRst <= 1'b0;
      clkSel  <= 2'd3;
      cmdRd   <= 1'b0;
      phyAddr <= '0;
      phyReg  <= '0;
      wrWord  <= '0;
    end else if (regWrEn) begin
      case (regSel)
        SEL_CFG: begin
          mgmtRst <= regWrData[15];
          clkSel  <= regWrData[1:0];
        end
        SEL_CMD:   cmdRd <= regWrData[0];
        SEL_ADDR: begin
          phyAddr <= regWrData[12:8];
          phyReg  <= regWrData[4:0];
        end
        SEL_WDATA: wrWord <= regWrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frame   <= '1;
      rdShift <= '0;
      rdWord  <= '0;
    end else begin
      if (strb.loadWr)
        frame <= {PRE_START, 2'b01, phyAddr, phyReg, 2'b10, regWrData};
      else if (strb.loadRd)
        frame <= {PRE_START, 2'b10, phyAddr, phyReg, 2'b11, {REG_W{1'b1}}};
      else if (strb.shift)
        frame <= {frame[FRAME_LEN-2:0], 1'b1};
      if (strb.capture) rdShift <= {rdShift[REG_W-2:0], mdioIn};
      if (strb.latch)   rdWord  <= rdShift;
    end
  end

  assign mdioOut = frame[FRAME_LEN-1];

  always_comb begin
    case (regSel)
      SEL_CFG:   regRdData = {mgmtRst, 13'b0, clkSel};
      SEL_CMD:   regRdData = {15'b0, cmdRd};
      SEL_ADDR:  regRdData = {3'b0, phyAddr, 3'b0, phyReg};
      SEL_WDATA: regRdData = wrWord;
      SEL_RDATA: regRdData = rdWord;
      SEL_STAT:  regRdData = {14'b0, notValid, busy};
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV0 = 4,
  parameter int DIV1 = 10,
  parameter int DIV2 = 20,
  parameter int DIV3 = 40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic                 mdc,
  output logic                 mdioOut,
  output logic                 mdioOe,
  input  logic                 mdioIn
);
  localparam int MAX01   = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int MAX23   = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int MAX_DIV = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CNT_W   = $clog2(MAX_DIV + 1);

  mdioStrobe_t strb;
  logic        busy, notValid, mgmtRst;
  logic [1:0]  clkSel;

  mdio_ctrl #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .mgmtRst(mgmtRst), .clkSel(clkSel),
    .regWrEn(regWrEn), .regSel(regSel), .cmdBit(regWrData[0]),
    .strb(strb), .busy(busy), .notValid(notValid), .mdc(mdc), .mdioOe(mdioOe)
  );

  mdio_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .mdioIn(mdioIn), .busy(busy), .notValid(notValid),
    .regRdData(regRdData), .mdioOut(mdioOut), .mgmtRst(mgmtRst), .clkSel(clkSel)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [REG_SEL_W-1:0] regSel,
  input logic                 regWrEn,
  input logic                 busy,
  input logic                 notValid,
  input logic                 mgmtRst,
  input logic                 mdc,
  input logic                 mdioOut,
  input logic                 mdioOe
);
  // R4: an accepted write-data store raises busy on the next edge
  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == SEL_WDATA && !busy && !mgmtRst) |=> busy);

  // R8: the bus is quiet whenever no frame runs
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  // R8: the driven bit changes only at a falling MDC edge
  p_out_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdioOut));

  // R5: not-valid is only ever up during a frame
  p_notvalid_r5: assert property (@(posedge clk) disable iff (!rstN)
    notValid |-> busy);

  // R6: management reset forces the engine idle
  p_mgmt_rst_r6: assert property (@(posedge clk) disable iff (!rstN)
    mgmtRst |=> (!busy && !notValid && !mdc));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .busy(busy),
  .notValid(notValid), .mgmtRst(mgmtRst), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  regSel;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  always #2 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  // reference model state
  bit          mActive, mIsRead, mNotValid, mCfgRst, mCmd;
  int          mK, mDiv;
  logic [1:0]  mCfgSel;
  logic [63:0] mFrame;
  logic [4:0]  mPhy, mReg;
  logic [15:0] mWdata, mRd, resp;

  function automatic int divOf(logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 10;
      2'd2: return 20;
      default: return 40;
    endcase
  endfunction

  function automatic logic [15:0] expRead(logic [2:0] s);
    case (s)
      3'd0: return {mCfgRst, 13'b0, mCfgSel};
      3'd1: return {15'b0, mCmd};
      3'd2: return {3'b0, mPhy, 3'b0, mReg};
      3'd3: return mWdata;
      3'd4: return mRd;
      3'd5: return {14'b0, mNotValid, mActive};
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit canStart;
    if (!rstN) begin
      mActive = 0; mIsRead = 0; mNotValid = 0; mCfgRst = 0; mCmd = 0;
      mK = 0; mDiv = 40; mCfgSel = 2'd3; mFrame = '1;
      mPhy = 0; mReg = 0; mWdata = 0; mRd = 0;
    end else begin
      canStart = !mActive && !mCfgRst;
      if (mCfgRst) begin
        mActive = 0; mNotValid = 0;
      end else if (mActive) begin
        mK++;
        if (mK == 64 * mDiv) begin
          mActive = 0;
          if (mIsRead) begin mNotValid = 0; mRd = resp; end
        end
      end
      if (canStart && regWrEn && regSel == 3'd3) begin
        mActive = 1; mIsRead = 0; mK = 0; mDiv = divOf(mCfgSel);
        mFrame = {32'hFFFF_FFFF, 2'b01, 2'b01, mPhy, mReg, 2'b10, regWrData};
      end
      if (canStart && regWrEn && regSel == 3'd1 && regWrData[0]) begin
        mActive = 1; mIsRead = 1; mNotValid = 1; mK = 0; mDiv = divOf(mCfgSel);
        mFrame = {32'hFFFF_FFFF, 2'b01, 2'b10, mPhy, mReg, 2'b11, 16'hFFFF};
      end
      if (regWrEn) begin
        case (regSel)
          3'd0: begin mCfgRst = regWrData[15]; mCfgSel = regWrData[1:0]; end
          3'd1: mCmd = regWrData[0];
          3'd2: begin mPhy = regWrData[12:8]; mReg = regWrData[4:0]; end
          3'd3: mWdata = regWrData;
          default: ;
        endcase
      end
    end
  end

  // compare on every clock, 1 ns after the edge; also act as the PHY
  always @(posedge clk) begin : compare
    int bitNo;
    bit eMdc, eOe;
    #1;
    if (rstN && !finished) begin
      bitNo = mActive ? (mK / mDiv) : 0;
      eMdc  = mActive && ((mK % mDiv) >= (mDiv / 2));
      eOe   = mActive && (!mIsRead || bitNo < 46);
      chk(mActive ? "R7 mdc" : "R8 mdc idle", {15'b0, mdc}, {15'b0, eMdc});
      chk(mIsRead ? "R3 oe" : "R8 oe", {15'b0, mdioOe}, {15'b0, eOe});
      if (eOe) chk("R2 mdio bit", {15'b0, mdioOut}, {15'b0, mFrame[63 - bitNo]});
      case (regSel)
        3'd0: chk("R7 cfg", regRdData, expRead(regSel));
        3'd1: chk("R3 cmd", regRdData, expRead(regSel));
        3'd2: chk("R1 addr", regRdData, expRead(regSel));
        3'd3: chk("R2 wdata", regRdData, expRead(regSel));
        3'd4: chk("R5 rdata", regRdData, expRead(regSel));
        3'd5: chk("R4 status", regRdData, expRead(regSel));
        default: chk("R10 unused", regRdData, expRead(regSel));
      endcase
      if (mActive && mIsRead && bitNo >= 48) mdioIn = resp[15 - (bitNo - 48)];
      else mdioIn = 1'b1;
    end
  end

  task automatic busWr(logic [2:0] s, logic [15:0] d);
    regSel = s; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 3'd5;
  endtask

  task automatic rdChk(logic [2:0] s, logic [15:0] exp, string req);
    regSel = s;
    #1;
    chk(req, regRdData, exp);
    regSel = 3'd5;
  endtask

  task automatic waitIdle();
    while (mActive) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    nBad++;
    $display("FAIL watchdog expired at %0t", $time);
    finish();
  end

  initial begin
    rstN = 0; regSel = 3'd5; regWrEn = 0; regWrData = 0; mdioIn = 1; resp = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    rdChk(3'd5, 16'h0000, "R4 reset status");
    rdChk(3'd0, 16'h0003, "R7 reset divisor");
    rdChk(3'd4, 16'h0000, "R5 reset rdata");
    rdChk(3'd6, 16'h0000, "R10 select 6");

    busWr(3'd0, 16'h0000);
    busWr(3'd2, 16'hF3EA);
    rdChk(3'd2, 16'h130A, "R1 address fields");

    // write frame, divide by 4
    busWr(3'd3, 16'hA5C3);
    rdChk(3'd5, 16'h0001, "R4 busy after write start");
    waitIdle();
    rdChk(3'd3, 16'hA5C3, "R2 write data readback");

    // start request on the final cycle of a frame
    busWr(3'd3, 16'h0F0F);
    while (!(mActive && mK == 64 * mDiv - 1)) @(negedge clk);
    busWr(3'd3, 16'h1234);
    rdChk(3'd5, 16'h0000, "R9 start on finishing edge ignored");
    repeat (3) @(negedge clk);
    rdChk(3'd5, 16'h0000, "R9 still idle");

    // read frame with a store attempt during it
    resp = 16'h3C96;
    busWr(3'd1, 16'h0001);
    rdChk(3'd5, 16'h0003, "R5 busy and not valid");
    repeat (50) @(negedge clk);
    busWr(3'd3, 16'hFFFF);
    busWr(3'd1, 16'h0001);
    waitIdle();
    rdChk(3'd4, 16'h3C96, "R5 read word");
    rdChk(3'd1, 16'h0001, "R3 command held");
    busWr(3'd1, 16'h0000);
    rdChk(3'd1, 16'h0000, "R3 command cleared");

    // read at divide by 10
    busWr(3'd0, 16'h0001);
    resp = 16'h8001;
    busWr(3'd1, 16'h0001);
    waitIdle();
    rdChk(3'd4, 16'h8001, "R5 read word div10");

    // management reset mid-frame
    busWr(3'd3, 16'h5555);
    repeat (100) @(negedge clk);
    busWr(3'd0, 16'h8000);
    @(negedge clk);
    rdChk(3'd5, 16'h0000, "R6 reset stops frame");
    busWr(3'd1, 16'h0001);
    busWr(3'd3, 16'h7777);
    rdChk(3'd5, 16'h0000, "R6 starts ignored in reset");
    busWr(3'd0, 16'h0002);

    // divisor latched at start
    busWr(3'd3, 16'h5A5A);
    repeat (200) @(negedge clk);
    busWr(3'd0, 16'h0000);
    rdChk(3'd5, 16'h0001, "R7 frame continues");
    waitIdle();

    // read at divide by 40
    busWr(3'd0, 16'h0003);
    resp = 16'hC35A;
    busWr(3'd1, 16'h0001);
    waitIdle();
    rdChk(3'd4, 16'hC35A, "R5 read word div40");
    rdChk(3'd5, 16'h0000, "R4 idle at end");
    rdChk(3'd7, 16'h0000, "R10 select 7");
    repeat (4) @(negedge clk);
    finish();
  end
endmodule